// File: doc/BRIEF.md
# DRAM Refresh Request Generator

This block issues DRAM refresh cycles without any software action per cycle. Software programs a refresh interval, a base address and an enable bit through a small register write port. The block counts the interval down and, when it runs out, asks the bus unit for a memory read. The bus unit runs that read like any other memory read, so the address is decoded and the chip select covering it goes active. After each acknowledged cycle a 9-bit row counter steps forward, which walks the refresh address through the DRAM rows.

The generator runs only while the enhanced operating mode input is high. Its timer advances only on cycles where the clock-enable tick is high. When a power-save clock divider thins out those ticks, the real refresh rate drops by the division factor. Software must reprogram the interval on entering or leaving power save if it needs a fixed refresh rate.

Register map on `cfgSel`: 0 = interval, taken from the low 16 bits of `cfgData`; 1 = base address, taken from all of `cfgData`; 2 = control, with bit 0 as the enable.

Top module: `dram_refresh_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the enable, the pending request, the row counter, the interval and the base, so that afterwards `reqValid` is 0 and `reqAddr` is 0.
- R2: While `enhancedMode` is low, `reqValid` stays low, the interval timer holds its value, and a request that was pending is dropped.
- R3: After a control write with bit 0 = 1 and an interval P of at least 1, `reqValid` rises right after the clock edge of the P-th following cycle in which `tickEn` and `enhancedMode` are both high. Cycles with `tickEn` low do not count.
- R4: `reqAddr` equals the base address plus the zero-extended row counter, modulo 2^20.
- R5: `reqValid` stays high until an edge where `reqAck` is high. An interval that runs out while a request is already pending reloads the timer but does not queue a second request, so one acknowledge clears the request.
- R6: Each edge with `reqValid` and `reqAck` both high advances the row counter by one, and the counter wraps from 511 to 0. At all other edges the row counter holds.
- R7: A control write with bit 0 = 0 clears the pending request and stops the timer. A control write with bit 0 = 1 reloads the timer from the full interval.
- R8: If an acknowledge and a timer expiry fall on the same edge, the row counter advances and `reqValid` stays high for the new request.
- R9: An interval of 0 behaves like an interval of 1, so the timer expires on every counted tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enhancedMode | input | 1 | Operating-mode gate; the block is idle when low |
| tickEn | input | 1 | Clock-enable tick that advances the interval timer |
| cfgWe | input | 1 | Register write strobe |
| cfgSel | input | 2 | Register select: 0 interval, 1 base, 2 control |
| cfgData | input | 20 | Register write data |
| reqValid | output | 1 | Refresh read request to the bus unit |
| reqAck | input | 1 | Bus unit accepts the pending request |
| reqAddr | output | 20 | Memory address of the refresh read |

## Verification
The timer expiry and the bus acknowledge can land on the same clock edge. One expiry would raise a new request while the acknowledge retires the old one. The bench sets the interval to 4, restarts the timer so that the first request is pending, and then holds off the acknowledge until the edge on which the second expiry falls. It expects `reqValid` to stay high and the address to step by one. A long run with an interval of 0 and the acknowledge held high makes the two meet on every edge, and the scoreboard then compares every completed handshake address across the row wrap.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  // Register select codes on the configuration port.
  localparam logic [1:0] SEL_PERIOD = 2'd0;
  localparam logic [1:0] SEL_BASE   = 2'd1;
  localparam logic [1:0] SEL_CTRL   = 2'd2;

  // Strobes from the control section to the datapath.
  typedef struct packed {
    logic loadCount;   // reload interval timer from the period register
    logic decCount;    // count the timer down by one tick
    logic rowAdvance;  // a refresh cycle was accepted: step the row
  } rfStrobes_t;

endpackage

// File: rtl/refresh_datapath.sv
module refresh_datapath
  import refresh_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 16,
  parameter int ROW_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  input  rfStrobes_t        strobe,
  output logic              countLow,
  output logic [ADDR_W-1:0] rowAddr
);

  logic [CNT_W-1:0]  periodQ;
  logic [CNT_W-1:0]  countQ;
  logic [ADDR_W-1:0] baseQ;
  logic [ROW_W-1:0]  rowQ;
  logic [ADDR_W-1:0] rowExt;

  // Configuration registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      periodQ <= '0;
      baseQ   <= '0;
    end else if (cfgWe) begin
      if (cfgSel == SEL_PERIOD) periodQ <= cfgData[CNT_W-1:0];
      if (cfgSel == SEL_BASE)   baseQ   <= cfgData;
    end
  end

  // Interval timer. A reload takes the period value held before this edge.
  always_ff @(posedge clk) begin
    if (rst)                   countQ <= '0;
    else if (strobe.loadCount) countQ <= periodQ;
    else if (strobe.decCount)  countQ <= countQ - 1'b1;
  end

  // The timer runs out at one; a period of zero is treated as one.
  assign countLow = (countQ <= CNT_W'(1));

  // Row counter wraps by its natural width.
  always_ff @(posedge clk) begin
    if (rst)                    rowQ <= '0;
    else if (strobe.rowAdvance) rowQ <= rowQ + 1'b1;
  end

  generate
    if (ROW_W < ADDR_W) begin : gRowPad
      assign rowExt = {{(ADDR_W-ROW_W){1'b0}}, rowQ};
    end else begin : gRowTrim
      assign rowExt = rowQ[ADDR_W-1:0];
    end
  endgenerate

  assign rowAddr = baseQ + rowExt;

  // R6: an accepted cycle steps the row by exactly one (wrapping).
  a_r6_row_step: assert property (@(posedge clk) disable iff (rst)
    strobe.rowAdvance |=> rowQ == $past(rowQ) + 1'b1);

  // R6: without an accepted cycle the row holds.
  a_r6_row_hold: assert property (@(posedge clk) disable iff (rst)
    !strobe.rowAdvance |=> $stable(rowQ));

  // R7: the timer stays put when neither a reload nor a tick happens.
  a_r7_count_hold: assert property (@(posedge clk) disable iff (rst)
    (!strobe.loadCount && !strobe.decCount) |=> $stable(countQ));

endmodule

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import refresh_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enhancedMode,
  input  logic       tickEn,
  input  logic       cfgWe,
  input  logic [1:0] cfgSel,
  input  logic       enBit,
  input  logic       countLow,
  input  logic       reqAck,
  output rfStrobes_t strobe,
  output logic       reqValid
);

  logic enableQ;
  logic pendingQ;
  logic ctrlWrite;
  logic stopWrite;
  logic startWrite;
  logic running;
  logic expire;
  logic accepted;

  assign ctrlWrite  = cfgWe && (cfgSel == SEL_CTRL);
  assign stopWrite  = ctrlWrite && !enBit;
  assign startWrite = ctrlWrite && enBit;
  assign running    = enableQ && enhancedMode;
  assign expire     = running && tickEn && countLow;
  assign accepted   = pendingQ && reqAck;

  always_ff @(posedge clk) begin
    if (rst)            enableQ <= 1'b0;
    else if (ctrlWrite) enableQ <= enBit;
  end

  // Pending request: a stop write or leaving the mode drops it; an expiry
  // wins over a simultaneous acknowledge, so no request is lost.
  always_ff @(posedge clk) begin
    if (rst)                pendingQ <= 1'b0;
    else if (stopWrite)     pendingQ <= 1'b0;
    else if (!enhancedMode) pendingQ <= 1'b0;
    else if (expire)        pendingQ <= 1'b1;
    else if (accepted)      pendingQ <= 1'b0;
  end

  always_comb begin
    strobe            = '0;
    strobe.loadCount  = startWrite || expire;
    strobe.decCount   = running && tickEn && !countLow && !startWrite;
    strobe.rowAdvance = accepted;
  end

  assign reqValid = pendingQ;

  // R1: reset leaves the block idle.
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!pendingQ && !enableQ));

  // R2: outside the enhanced mode no request can be outstanding.
  a_r2_mode_gate: assert property (@(posedge clk) disable iff (rst)
    !enhancedMode |=> !pendingQ);

  // R5: a request is held until it is acknowledged.
  a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (pendingQ && !reqAck && enhancedMode && !stopWrite) |=> pendingQ);

  // R7: a stop write clears both the enable and the request.
  a_r7_stop_clears: assert property (@(posedge clk) disable iff (rst)
    stopWrite |=> (!pendingQ && !enableQ));

  // R8: acknowledge and expiry together keep a request outstanding.
  a_r8_ack_meets_expiry: assert property (@(posedge clk) disable iff (rst)
    (accepted && expire && !stopWrite) |=> pendingQ);

endmodule

// File: rtl/dram_refresh_gen.sv
module dram_refresh_gen
  import refresh_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 16,
  parameter int ROW_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enhancedMode,
  input  logic              tickEn,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  output logic              reqValid,
  input  logic              reqAck,
  output logic [ADDR_W-1:0] reqAddr
);

  rfStrobes_t strobe;
  logic       countLow;

  refresh_ctrl uCtrl (
    .clk          (clk),
    .rst          (rst),
    .enhancedMode (enhancedMode),
    .tickEn       (tickEn),
    .cfgWe        (cfgWe),
    .cfgSel       (cfgSel),
    .enBit        (cfgData[0]),
    .countLow     (countLow),
    .reqAck       (reqAck),
    .strobe       (strobe),
    .reqValid     (reqValid)
  );

  refresh_datapath #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .ROW_W  (ROW_W)
  ) uPath (
    .clk      (clk),
    .rst      (rst),
    .cfgWe    (cfgWe),
    .cfgSel   (cfgSel),
    .cfgData  (cfgData),
    .strobe   (strobe),
    .countLow (countLow),
    .rowAddr  (reqAddr)
  );

  // R4: the address of an outstanding request does not move under the bus.
  a_r4_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !reqAck && !cfgWe) |=> $stable(reqAddr));

endmodule

// File: tb/dram_refresh_gen_test.sv
`timescale 1ns/100ps
module dram_refresh_gen_test;

  localparam int AW = 20;
  localparam logic [AW-1:0] MASK = '1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enhancedMode = 1'b0;
  logic          tickEn = 1'b0;
  logic          cfgWe = 1'b0;
  logic [1:0]    cfgSel = 2'd0;
  logic [AW-1:0] cfgData = '0;
  logic          reqValid;
  logic          reqAck = 1'b0;
  logic [AW-1:0] reqAddr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [AW-1:0] expQ[$];

  dram_refresh_gen uut (
    .clk(clk), .rst(rst), .enhancedMode(enhancedMode), .tickEn(tickEn),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .reqValid(reqValid), .reqAck(reqAck), .reqAddr(reqAddr)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [AW-1:0] data);
    cfgSel = sel; cfgData = data; cfgWe = 1'b1;
    step(1);
    cfgWe = 1'b0;
  endtask

  // Driver: record the expected address, then present one acknowledge.
  task automatic ackOne(input logic [AW-1:0] exp);
    expQ.push_back(exp);
    reqAck = 1'b1;
    step(1);
    reqAck = 1'b0;
  endtask

  task automatic expectValid(input logic exp, input string tag);
    check(reqValid === exp, tag, 32'(reqValid), 32'(exp));
  endtask

  task automatic expectAddr(input logic [AW-1:0] exp, input string tag);
    check(reqAddr === exp, tag, 32'(reqAddr), 32'(exp));
  endtask

  // Monitor: every completed handshake is compared with the scoreboard.
  always @(negedge clk) begin
    if (!rst && reqValid === 1'b1 && reqAck === 1'b1) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R4 handshake without expectation", 32'(reqAddr), 32'hFFFFFFFF);
      end else begin
        logic [AW-1:0] e;
        e = expQ.pop_front();
        check(reqAddr === e, "R4 R6 handshake address", 32'(reqAddr), 32'(e));
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int row;
    step(3);
    rst = 1'b0;
    // R1 reset state
    expectValid(1'b0, "R1 reset reqValid");
    expectAddr('0, "R1 reset address");

    // R3 interval with a tick every cycle, period 4
    wr(2'd1, 20'h01000);
    wr(2'd0, 20'd4);
    enhancedMode = 1'b1; tickEn = 1'b1;
    wr(2'd2, 20'd1);
    step(3);
    expectValid(1'b0, "R3 before interval");
    step(1);
    expectValid(1'b1, "R3 at interval");
    expectAddr(20'h01000, "R4 base plus row 0");
    ackOne(20'h01000);
    expectValid(1'b0, "R5 cleared by ack");
    expectAddr(20'h01001, "R6 row advanced");
    step(2);
    expectValid(1'b0, "R3 reload before second expiry");
    step(1);
    expectValid(1'b1, "R3 second expiry");
    // R5 further expiries while pending do not queue
    step(8);
    expectValid(1'b1, "R5 held while unacknowledged");
    ackOne(20'h01001);
    expectValid(1'b0, "R5 single ack clears, no queued request");
    expectAddr(20'h01002, "R6 one step per ack");
    wr(2'd2, 20'd0);

    // R3 ticks gated by tickEn
    tickEn = 1'b0;
    wr(2'd2, 20'd1);
    for (int i = 0; i < 3; i++) begin
      tickEn = 1'b1; step(1);
      tickEn = 1'b0; step(1);
    end
    expectValid(1'b0, "R3 three ticks only");
    step(5);
    expectValid(1'b0, "R3 no tick no count");
    tickEn = 1'b1; step(1);
    tickEn = 1'b0;
    expectValid(1'b1, "R3 fourth tick expires");
    ackOne(20'h01002);

    // R2 mode gate: timer frozen and no request
    enhancedMode = 1'b0;
    wr(2'd2, 20'd1);
    tickEn = 1'b1;
    step(10);
    expectValid(1'b0, "R2 no request outside mode");
    enhancedMode = 1'b1;
    step(3);
    expectValid(1'b0, "R2 timer held while mode low");
    step(1);
    expectValid(1'b1, "R2 full interval after mode returns");
    enhancedMode = 1'b0;
    step(1);
    expectValid(1'b0, "R2 pending dropped on mode exit");
    enhancedMode = 1'b1;
    wr(2'd2, 20'd0);

    // R7 stop clears, restart reloads
    wr(2'd2, 20'd1);
    step(4);
    expectValid(1'b1, "R7 request before stop");
    wr(2'd2, 20'd0);
    expectValid(1'b0, "R7 stop clears request");
    step(10);
    expectValid(1'b0, "R7 timer stopped");
    expectAddr(20'h01003, "R7 row untouched by stop");
    wr(2'd2, 20'd1);
    step(3);
    expectValid(1'b0, "R7 restart from full interval");
    step(1);
    expectValid(1'b1, "R7 restart expiry");

    // R8 acknowledge on the same edge as the next expiry
    step(3);
    ackOne(20'h01003);
    expectValid(1'b1, "R8 new request survives coincident ack");
    expectAddr(20'h01004, "R8 row advanced on coincident ack");
    ackOne(20'h01004);
    expectValid(1'b0, "R8 later ack clears");
    wr(2'd2, 20'd0);

    // R9 period zero acts as one
    wr(2'd0, 20'd0);
    wr(2'd2, 20'd1);
    step(1);
    expectValid(1'b1, "R9 period zero expires on first tick");
    wr(2'd2, 20'd0);

    // R6 row wrap with base near the top of the address space (R4 modulo)
    wr(2'd1, 20'hFFF00);
    wr(2'd2, 20'd1);
    step(1);
    row = 5;
    for (int i = 0; i < 507; i++) begin
      if (row == 511) expectAddr(20'h000FF, "R4 address wraps modulo width");
      expQ.push_back((20'hFFF00 + 20'(row)) & MASK);
      row = (row + 1) % 512;
      reqAck = 1'b1;
      step(1);
    end
    reqAck = 1'b0;
    expectAddr(20'hFFF00, "R6 row wraps 511 to 0");
    expectValid(1'b1, "R8 back-to-back expiry keeps request");
    wr(2'd2, 20'd0);
    expectValid(1'b0, "R7 stop after burst");

    // R1 reset mid-run
    wr(2'd2, 20'd1);
    rst = 1'b1; step(1); rst = 1'b0;
    step(3);
    expectValid(1'b0, "R1 reset disables");
    expectAddr('0, "R1 reset clears base and row");
    check(expQ.size() == 0, "R6 all expected handshakes seen", 32'(expQ.size()), 32'd0);
    summary();
  end

endmodule